// File: doc/BRIEF.md
# SECDED (8,4) Codec

This block guards a 4-bit nibble with a single-error-correcting, double-error-detecting Hamming code. The encoding side turns the nibble into an 8-bit word: three check bits, the four data bits, and one parity bit over the whole word. The decoding side takes an 8-bit word that may be damaged and returns the nibble. It reports whether one bit was fixed, or whether two bits were wrong and could not be fixed.

The two sides work independently of each other. Each one captures its input on a cycle where its valid strobe is high, and presents the result, with a valid strobe, one clock later. When no input is offered, the last result stays on the outputs. The check bits sit at positions 1, 2 and 4 of the word, so the syndrome read as a number is the position of a single bad bit. The whole-word parity bit is what separates a single error from a double error.

Top module: `secded_codec`

## Requirements
- R1: While rst_n is low and after it rises, until the first accepted input, both valid outputs, enc_out_code, dec_out_data, dec_out_corrected and dec_out_double are all zero.
- R2: With data bits d1..d4 = enc_in_data[0..3], the 8-bit word (bit 0 = position 1) is laid out from position 7 down to 1 as d4, d3, d2, c3, d1, c2, c1. The check bits are c1 = d1^d2^d4, c2 = d1^d3^d4 and c3 = d2^d3^d4.
- R3: Bit 7 of enc_out_code (position 8) is chosen so that the full 8-bit word has an even number of ones.
- R4: Each output valid equals the matching input valid from the previous clock. The data, code and flag outputs change only one cycle after an accepted input, and otherwise they hold their values.
- R5: A word with no error decodes to its data bits, with both flags low.
- R6: A word with one flipped data bit (position 3, 5, 6 or 7) decodes to the original data, with dec_out_corrected high and dec_out_double low.
- R7: A word with one flipped check bit (position 1, 2 or 4) decodes to the unchanged data, with dec_out_corrected high.
- R8: A word whose only flipped bit is the whole-word parity bit (position 8) decodes to the unchanged data, with dec_out_corrected high.
- R9: A word with two flipped bits raises dec_out_double and keeps dec_out_corrected low. dec_out_data carries the received bits at positions 3, 5, 6 and 7, unmodified.
- R10: dec_out_corrected and dec_out_double are never high together. dec_out_corrected follows whether the word accepted one cycle earlier had odd whole-word parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_in_valid | input | 1 | Encoding input strobe |
| enc_in_data | input | 4 | Nibble to encode |
| enc_out_valid | output | 1 | Encoded word valid |
| enc_out_code | output | 8 | Encoded word, bit 0 = position 1 |
| dec_in_valid | input | 1 | Decoding input strobe |
| dec_in_code | input | 8 | Received word, bit 0 = position 1 |
| dec_out_valid | output | 1 | Decoding result valid |
| dec_out_data | output | 4 | Recovered nibble |
| dec_out_corrected | output | 1 | A single bit error was found and handled |
| dec_out_double | output | 1 | An uncorrectable double error was found |

## Verification
The decoder properties assume the received word carries no more than two flipped bits. With three or more errors, the parity-based flags are only a best guess, and the bench never offers such words. The properties also assume the valid inputs are low at the edge where reset is released. The stimulus changes inputs only on falling edges, holds both strobes low across reset, and builds every decoder input from a correct encoding with zero, one or two chosen positions inverted.

// File: rtl/secded_pkg.sv
package secded_pkg;

   // Mask of the Hamming positions (1-based, bit pos-1) that check bit k covers.
   function automatic logic [63:0] cover_mask(input int unsigned k, input int unsigned ham_w);
      logic [63:0] m;
      m = '0;
      for (int unsigned pos = 1; pos <= ham_w; pos++) begin
         if (((pos >> k) & 1) == 1) m[pos-1] = 1'b1;
      end
      return m;
   endfunction

   // True when a 1-based position holds a check bit (a power of two).
   function automatic bit is_check_pos(input int unsigned pos);
      return (pos & (pos - 1)) == 0;
   endfunction

   // Data index stored at a non-check position.
   function automatic int unsigned data_idx(input int unsigned pos);
      return pos - $clog2(pos + 1) - 1;
   endfunction

   // Position holding data index idx.
   function automatic int unsigned data_pos(input int unsigned idx, input int unsigned ham_w);
      int unsigned cnt;
      int unsigned found;
      cnt   = 0;
      found = 0;
      for (int unsigned pos = 1; pos <= ham_w; pos++) begin
         if (!is_check_pos(pos)) begin
            if (cnt == idx) found = pos;
            cnt++;
         end
      end
      return found;
   endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
   parameter int unsigned PAR_W = 3,
   localparam int unsigned HAM_W  = (1 << PAR_W) - 1,
   localparam int unsigned DATA_W = HAM_W - PAR_W,
   localparam int unsigned CODE_W = HAM_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [CODE_W-1:0] out_code
);

   logic [HAM_W-1:0] spread;
   logic [HAM_W-1:0] ham;
   logic             whole_par;

   for (genvar j = 1; j <= HAM_W; j++) begin : g_pos
      if (secded_pkg::is_check_pos(j)) begin : g_chk
         localparam int unsigned K = $clog2(j);
         localparam logic [63:0] MASK = secded_pkg::cover_mask(K, HAM_W);
         assign spread[j-1] = 1'b0;
         assign ham[j-1]    = ^(spread & MASK[HAM_W-1:0]);
      end else begin : g_dat
         localparam int unsigned IDX = secded_pkg::data_idx(j);
         assign spread[j-1] = in_data[IDX];
         assign ham[j-1]    = in_data[IDX];
      end
   end

   assign whole_par = ^ham;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_code  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_code <= {whole_par, ham};
      end
   end

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
   parameter int unsigned PAR_W = 3,
   localparam int unsigned HAM_W  = (1 << PAR_W) - 1,
   localparam int unsigned CODE_W = HAM_W + 1
) (
   input  logic [CODE_W-1:0] code,
   output logic [PAR_W-1:0]  syn,
   output logic              odd
);

   for (genvar k = 0; k < PAR_W; k++) begin : g_syn
      localparam logic [63:0] MASK = secded_pkg::cover_mask(k, HAM_W);
      assign syn[k] = ^(code[HAM_W-1:0] & MASK[HAM_W-1:0]);
   end

   assign odd = ^code;

endmodule

// File: rtl/secded_fix.sv
module secded_fix #(
   parameter int unsigned PAR_W = 3,
   localparam int unsigned HAM_W  = (1 << PAR_W) - 1,
   localparam int unsigned DATA_W = HAM_W - PAR_W
) (
   input  logic [DATA_W-1:0] raw,
   input  logic [PAR_W-1:0]  syn,
   input  logic              odd,
   output logic [DATA_W-1:0] data,
   output logic              cor,
   output logic              dbl
);

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam int unsigned POS = secded_pkg::data_pos(i, HAM_W);
      logic hit;
      assign hit     = odd && (syn == PAR_W'(POS));
      assign data[i] = raw[i] ^ hit;
   end

   assign cor = odd;
   assign dbl = !odd && (syn != '0);

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
   parameter int unsigned PAR_W = 3,
   localparam int unsigned HAM_W  = (1 << PAR_W) - 1,
   localparam int unsigned DATA_W = HAM_W - PAR_W,
   localparam int unsigned CODE_W = HAM_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CODE_W-1:0] in_code,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_cor,
   output logic              out_dbl
);

   logic [PAR_W-1:0]  syn;
   logic              odd;
   logic [DATA_W-1:0] raw;
   logic [DATA_W-1:0] fixed;
   logic              cor;
   logic              dbl;

   for (genvar i = 0; i < DATA_W; i++) begin : g_raw
      localparam int unsigned POS = secded_pkg::data_pos(i, HAM_W);
      assign raw[i] = in_code[POS-1];
   end

   secded_syndrome #(.PAR_W(PAR_W)) i_syn (
      .code (in_code),
      .syn  (syn),
      .odd  (odd)
   );

   secded_fix #(.PAR_W(PAR_W)) i_fix (
      .raw  (raw),
      .syn  (syn),
      .odd  (odd),
      .data (fixed),
      .cor  (cor),
      .dbl  (dbl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_cor   <= 1'b0;
         out_dbl   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= fixed;
            out_cor  <= cor;
            out_dbl  <= dbl;
         end
      end
   end

endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
   parameter int unsigned PAR_W = 3,
   localparam int unsigned HAM_W  = (1 << PAR_W) - 1,
   localparam int unsigned DATA_W = HAM_W - PAR_W,
   localparam int unsigned CODE_W = HAM_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enc_in_valid,
   input  logic [DATA_W-1:0] enc_in_data,
   output logic              enc_out_valid,
   output logic [CODE_W-1:0] enc_out_code,
   input  logic              dec_in_valid,
   input  logic [CODE_W-1:0] dec_in_code,
   output logic              dec_out_valid,
   output logic [DATA_W-1:0] dec_out_data,
   output logic              dec_out_corrected,
   output logic              dec_out_double
);

   if (PAR_W < 2 || PAR_W > 6) begin : g_bad_par
      $error("secded_codec: PAR_W must lie in 2..6");
   end

   secded_enc #(.PAR_W(PAR_W)) i_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (enc_in_valid),
      .in_data   (enc_in_data),
      .out_valid (enc_out_valid),
      .out_code  (enc_out_code)
   );

   secded_dec #(.PAR_W(PAR_W)) i_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (dec_in_valid),
      .in_code   (dec_in_code),
      .out_valid (dec_out_valid),
      .out_data  (dec_out_data),
      .out_cor   (dec_out_corrected),
      .out_dbl   (dec_out_double)
   );

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
   parameter int unsigned PAR_W = 3,
   localparam int unsigned HAM_W  = (1 << PAR_W) - 1,
   localparam int unsigned DATA_W = HAM_W - PAR_W,
   localparam int unsigned CODE_W = HAM_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enc_in_valid,
   input logic              enc_out_valid,
   input logic [CODE_W-1:0] enc_out_code,
   input logic              dec_in_valid,
   input logic [CODE_W-1:0] dec_in_code,
   input logic              dec_out_valid,
   input logic [DATA_W-1:0] dec_out_data,
   input logic              dec_out_corrected,
   input logic              dec_out_double
);

   // R3
   enc_even_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_out_valid |-> (^enc_out_code) == 1'b0);

   // R4
   enc_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_in_valid |=> enc_out_valid);

   // R4
   dec_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_in_valid |=> !dec_out_valid);

   // R4
   dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_in_valid |=> $stable(dec_out_data) && $stable(dec_out_corrected) && $stable(dec_out_double));

   // R10
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_out_corrected && dec_out_double));

   // R10
   odd_word_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_in_valid && (^dec_in_code)) |=> dec_out_corrected);

   // R9
   even_word_not_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_in_valid && !(^dec_in_code)) |=> !dec_out_corrected);

endmodule

bind secded_codec secded_codec_chk #(.PAR_W(PAR_W)) i_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .enc_in_valid      (enc_in_valid),
   .enc_out_valid     (enc_out_valid),
   .enc_out_code      (enc_out_code),
   .dec_in_valid      (dec_in_valid),
   .dec_in_code       (dec_in_code),
   .dec_out_valid     (dec_out_valid),
   .dec_out_data      (dec_out_data),
   .dec_out_corrected (dec_out_corrected),
   .dec_out_double    (dec_out_double)
);

// File: tb/test_secded_codec.sv
`timescale 1ns/1ps
module test_secded_codec;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enc_in_valid = 1'b0;
   logic [3:0] enc_in_data = '0;
   logic       enc_out_valid;
   logic [7:0] enc_out_code;
   logic       dec_in_valid = 1'b0;
   logic [7:0] dec_in_code = '0;
   logic       dec_out_valid;
   logic [3:0] dec_out_data;
   logic       dec_out_corrected;
   logic       dec_out_double;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // reference model state, one clock behind the inputs
   logic       m_ev = 0;
   logic [7:0] m_ec = '0;
   string      m_et = "R1";
   logic       m_dv = 0;
   logic [3:0] m_dd = '0;
   logic       m_dc = 0;
   logic       m_db = 0;
   string      m_dt = "R1";

   always #2 clk = ~clk;

   secded_codec i_secded_codec (
      .clk               (clk),
      .rst_n             (rst_n),
      .enc_in_valid      (enc_in_valid),
      .enc_in_data       (enc_in_data),
      .enc_out_valid     (enc_out_valid),
      .enc_out_code      (enc_out_code),
      .dec_in_valid      (dec_in_valid),
      .dec_in_code       (dec_in_code),
      .dec_out_valid     (dec_out_valid),
      .dec_out_data      (dec_out_data),
      .dec_out_corrected (dec_out_corrected),
      .dec_out_double    (dec_out_double)
   );

   function automatic logic [7:0] ref_enc(input logic [3:0] d);
      logic c1, c2, c3;
      logic [6:0] w;
      c1 = d[0] ^ d[1] ^ d[3];
      c2 = d[0] ^ d[2] ^ d[3];
      c3 = d[1] ^ d[2] ^ d[3];
      w  = {d[3], d[2], d[1], c3, d[0], c2, c1};
      return {^w, w};
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic ev, input logic [3:0] ed, input string et,
                       input logic dv, input logic [7:0] dc, input logic [3:0] xd,
                       input logic xc, input logic xb, input string dt);
      @(negedge clk);
      chk(m_et, "enc_out_valid", enc_out_valid, m_ev);
      chk(m_et, "enc_out_code", enc_out_code, m_ec);
      chk(m_dt, "dec_out_valid", dec_out_valid, m_dv);
      chk(m_dt, "dec_out_data", dec_out_data, m_dd);
      chk(m_dt, "dec_out_corrected", dec_out_corrected, m_dc);
      chk(m_dt, "dec_out_double", dec_out_double, m_db);
      // R10 both flags never high together
      chk("R10", "flag_pair", dec_out_corrected & dec_out_double, 0);
      enc_in_valid = ev;
      enc_in_data  = ed;
      dec_in_valid = dv;
      dec_in_code  = dc;
      if (rst_n) begin
         m_ev = ev;
         m_dv = dv;
         if (ev) begin m_ec = ref_enc(ed); m_et = et; end
         else if (et != "") m_et = et;
         if (dv) begin m_dd = xd; m_dc = xc; m_db = xb; m_dt = dt; end
         else if (dt != "") m_dt = dt;
      end
   endtask

   task automatic idle(input string tag);
      step(0, 4'h0, tag, 0, 8'h00, 4'h0, 0, 0, tag);
   endtask

   initial begin : watchdog
      #(20000 * 4);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] w;
      logic [7:0] x;
      // R1 reset state, during and after reset
      idle("R1");
      idle("R1");
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1");
      idle("R1");

      // R2 R3 encode every nibble, R5 decode clean words alongside
      for (int d = 0; d < 16; d++) begin
         w = ref_enc(4'(d));
         step(1, 4'(d), "R2 R3", 1, w, 4'(d), 0, 0, "R5");
      end

      // single errors: R6 data slots, R7 check slots, R8 whole-word parity
      for (int d = 0; d < 16; d++) begin
         for (int p = 1; p <= 8; p++) begin
            string t;
            w = ref_enc(4'(d));
            x = w ^ (8'h01 << (p - 1));
            if (p == 8) t = "R8";
            else if (p == 1 || p == 2 || p == 4) t = "R7";
            else t = "R6";
            step(1, 4'(15 - d), "R2", 1, x, 4'(d), 1, 0, t);
         end
         // R4 hold across an idle cycle
         idle("R4");
      end

      // R9 double errors
      for (int d = 0; d < 16; d++) begin
         for (int a = 1; a <= 8; a++) begin
            for (int b = a + 1; b <= 8; b++) begin
               w = ref_enc(4'(d));
               x = w ^ (8'h01 << (a - 1)) ^ (8'h01 << (b - 1));
               step(0, 4'h0, "R4", 1, x, {x[6], x[5], x[4], x[2]}, 0, 1, "R9");
               if (((a + b + d) % 7) == 0) idle("R4");
            end
         end
      end

      // R4 outputs hold over several idle cycles, then a final clean word
      idle("R4");
      idle("R4");
      step(1, 4'hA, "R2", 1, ref_enc(4'h5), 4'h5, 0, 0, "R5");
      idle("R4");
      idle("R4");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule